// File: doc/BRIEF.md
# I2C Slave Address-Matching Interface

This block is the target-side front end of a two-wire I2C bus. A fast system clock oversamples the serial clock and data lines. The block finds START, repeated START and STOP conditions and takes the first byte after each START as a 7-bit address followed by a direction bit. When that address equals its own, the block acknowledges it. It then either collects written bytes and hands each one to the user logic, or shifts out bytes that the user logic supplies.

The block never drives the data line high. Its only data output is a pull-low enable that goes to an external open-drain pad. Five address bits are fixed by a parameter. The two lowest come from pins, so up to four copies can share one bus. A STOP at any point ends the current transfer, and the block goes back to listening.

Top module: `i2c_addr_slave`

## Requirements
- R1: Both bus inputs pass through a two-flop synchronizer. A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. Data bits are sampled on SCL rising, most significant bit first.
- R2: The first byte after a START is bits [7:1] address and bit 0 direction, with 1 meaning read. The address matches when it equals {ADDR_HI, addr_lo}, where addr_lo is the live value of the pins.
- R3: If the address does not match, the block never asserts sda_oe, rx_valid or tx_req until the next START.
- R4: After a matching address, and after each written data byte, sda_oe rises once SCL falls after the eighth bit. It falls when SCL falls at the end of the ninth (acknowledge) clock.
- R5: Each written byte gives a one-cycle rx_valid pulse, with rx_data holding the byte. The pulse comes in the same cycle that the acknowledge drive starts.
- R6: A STOP at any point, including mid-byte, returns the block to idle. A partial byte gives no rx_valid. Clocks that follow without a new START are not acknowledged.
- R7: A repeated START with no STOP before it restarts address reception, whatever the block was doing.
- R8: For a read, tx_req pulses for one cycle on the SCL rise of the acknowledge clock. tx_data is captured on the following SCL fall. Each bit is then driven as sda_oe = NOT bit, MSB first, changing only after SCL falls.
- R9: During a read, if SDA is low at the master-acknowledge clock, the block sends another byte. If SDA is high, the block releases the line and stays silent until a START or STOP.
- R10: sda_oe rises only while the synchronized SCL is low.
- R11: After reset, sda_oe, rx_valid and tx_req are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| addr_lo | input | 2 | Low two bits of the own address |
| sda_oe | output | 1 | 1 pulls the data line low |
| rx_valid | output | 1 | One-cycle strobe for a received write byte |
| rx_data | output | 8 | Last received write byte |
| tx_req | output | 1 | One-cycle request for the next read byte |
| tx_data | input | 8 | Read byte from the user side |

## Verification
Every output responds to a bus edge exactly three system clocks later: two synchronizer flops plus the edge-detect register. The bench's reference model records, at each bus edge it drives, what the outputs must become. It then pushes that expectation through a three-stage delay line and compares it with the ports on every falling clock edge. Strobes are modelled as single-cycle events in that line, so an early, late or doubled pulse fails on the cycle it occurs. Bit values on the wired line are also checked directly while SCL is high.

// File: rtl/i2c_addr_slave.sv
module i2c_addr_slave #(
  parameter logic [4:0] ADDR_HI = 5'b10100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] addr_lo,
  output logic       sda_oe,
  output logic       rx_valid,
  output logic [7:0] rx_data,
  output logic       tx_req,
  input  logic [7:0] tx_data
);
  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_WRITE, S_READ, S_ACK_OUT, S_ACK_IN, S_LOAD, S_WAIT
  } state_t;

  state_t     state;
  logic [1:0] scl_q, sda_q;
  logic       scl_d, sda_d;
  logic [7:0] shreg;
  logic [3:0] cnt;
  logic       rw;

  logic scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c, match;
  assign scl_s    = scl_q[1];
  assign sda_s    = sda_q[1];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_c  = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_c   = scl_s & scl_d & ~sda_d & sda_s;
  assign match    = (shreg[7:1] == {ADDR_HI, addr_lo});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q    <= 2'b11;
      sda_q    <= 2'b11;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
      state    <= S_IDLE;
      shreg    <= '0;
      cnt      <= '0;
      rw       <= 1'b0;
      sda_oe   <= 1'b0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
      tx_req   <= 1'b0;
    end else begin
      scl_q    <= {scl_q[0], scl_i};
      sda_q    <= {sda_q[0], sda_i};
      scl_d    <= scl_s;
      sda_d    <= sda_s;
      rx_valid <= 1'b0;
      tx_req   <= 1'b0;
      if (stop_c) begin
        state  <= S_IDLE;
        sda_oe <= 1'b0;
      end else if (start_c) begin
        state  <= S_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          S_ADDR, S_WRITE: begin
            if (scl_rise && cnt != 4'd8) begin
              shreg <= {shreg[6:0], sda_s};
              cnt   <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              cnt <= '0;
              if (state == S_WRITE) begin
                sda_oe   <= 1'b1;
                rx_valid <= 1'b1;
                rx_data  <= shreg;
                rw       <= 1'b0;
                state    <= S_ACK_OUT;
              end else if (match) begin
                sda_oe <= 1'b1;
                rw     <= shreg[0];
                state  <= S_ACK_OUT;
              end else begin
                state <= S_WAIT;
              end
            end
          end
          S_ACK_OUT: begin
            if (scl_rise) begin
              tx_req <= rw;
            end else if (scl_fall) begin
              if (rw) begin
                shreg  <= tx_data;
                sda_oe <= ~tx_data[7];
                cnt    <= '0;
                state  <= S_READ;
              end else begin
                sda_oe <= 1'b0;
                state  <= S_WRITE;
              end
            end
          end
          S_READ: begin
            if (scl_rise) begin
              cnt <= cnt + 4'd1;
            end else if (scl_fall) begin
              if (cnt == 4'd8) begin
                sda_oe <= 1'b0;
                state  <= S_ACK_IN;
              end else begin
                shreg  <= {shreg[6:0], 1'b0};
                sda_oe <= ~shreg[6];
              end
            end
          end
          S_ACK_IN: begin
            if (scl_rise) begin
              if (sda_s) begin
                state <= S_WAIT;
              end else begin
                tx_req <= 1'b1;
                state  <= S_LOAD;
              end
            end
          end
          S_LOAD: begin
            if (scl_fall) begin
              shreg  <= tx_data;
              sda_oe <= ~tx_data[7];
              cnt    <= '0;
              state  <= S_READ;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_addr_slave_chk.sv
module i2c_addr_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic sda_i,
  input logic sda_oe,
  input logic rx_valid,
  input logic tx_req
);
  AST_OE_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(sda_oe) |-> !$past(scl_i, 2)); // R10
  AST_RX_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) rx_valid |=> !rx_valid); // R5
  AST_TX_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) tx_req |=> !tx_req); // R8
  AST_RX_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n) rx_valid |-> sda_oe); // R4
  AST_STOP_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(scl_i, 2) && $past(scl_i, 3) && $past(sda_i, 2) && !$past(sda_i, 3)) |=> (!sda_oe && !rx_valid)); // R6
endmodule

bind i2c_addr_slave i2c_addr_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
  .sda_oe(sda_oe), .rx_valid(rx_valid), .tx_req(tx_req)
);

// File: tb/i2c_addr_slave_test.sv
module i2c_addr_slave_test;
  localparam logic [4:0] HI = 5'b10100;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_line;
  logic [1:0] addr_lo = 2'b10;
  logic sda_oe, rx_valid, tx_req;
  logic [7:0] rx_data;
  logic [7:0] tx_data = 8'h00;

  always #4 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_addr_slave #(.ADDR_HI(HI)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .addr_lo(addr_lo), .sda_oe(sda_oe), .rx_valid(rx_valid),
    .rx_data(rx_data), .tx_req(tx_req), .tx_data(tx_data)
  );

  int tests = 0, fails = 0, cycles = 0;
  string cur_req = "R11";
  bit running = 0;

  logic intent_oe = 1'b0;
  int rxv_set = 0, rxv_seen = 0, txr_set = 0, txr_seen = 0;
  logic [2:0] d_oe = '0, d_rxv = '0, d_txr = '0;
  logic [7:0] exp_rx = '0;
  logic [7:0] tx_q[$];

  task automatic chk(input string tag, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // model: expected ports are the intents of each bus edge, three clocks later
  always @(posedge clk) begin
    cycles++;
    d_oe  <= {d_oe[1:0], intent_oe};
    d_rxv <= {d_rxv[1:0], rxv_set != rxv_seen};
    d_txr <= {d_txr[1:0], txr_set != txr_seen};
    rxv_seen <= rxv_set;
    txr_seen <= txr_set;
    if (cycles == 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (running) begin
      chk(cur_req, "sda_oe", sda_oe, d_oe[2]);
      chk(cur_req, "rx_valid", rx_valid, d_rxv[2]);
      chk(cur_req, "tx_req", tx_req, d_txr[2]);
      if (d_rxv[2]) chk(cur_req, "rx_data", rx_data, exp_rx);
      if (tx_req && tx_q.size() > 0) tx_data <= tx_q.pop_front();
    end
  end

  task automatic half();
    repeat (Q) @(negedge clk);
  endtask

  task automatic send_start();
    sda_m = 1'b1; half(); scl_m = 1'b1; half();
    sda_m = 1'b0; half(); scl_m = 1'b0; intent_oe = 1'b0; half();
  endtask

  task automatic send_stop();
    sda_m = 1'b0; half(); scl_m = 1'b1; half();
    sda_m = 1'b1; intent_oe = 1'b0; half(); half();
  endtask

  task automatic wr_byte(input logic [7:0] v, input bit acked, input bit is_data,
                         input bit rd, input logic [7:0] first);
    for (int i = 7; i >= 0; i--) begin
      sda_m = v[i]; half(); scl_m = 1'b1; half(); half(); scl_m = 1'b0;
      if (i == 0 && acked) begin
        intent_oe = 1'b1;
        if (is_data) begin exp_rx = v; rxv_set++; end
      end
      half();
    end
    sda_m = 1'b1; half(); scl_m = 1'b1;
    if (acked && rd) txr_set++;
    half();
    chk(cur_req, "ack on line", int'(sda_line == 1'b0), int'(acked));
    half(); scl_m = 1'b0;
    intent_oe = (acked && rd) ? ~first[7] : 1'b0;
    half();
  endtask

  task automatic rd_byte(input logic [7:0] v, input bit mack, input logic [7:0] nxt);
    for (int i = 7; i >= 0; i--) begin
      half(); scl_m = 1'b1; half();
      chk(cur_req, "read bit", sda_line, v[i]);
      half(); scl_m = 1'b0;
      intent_oe = (i > 0) ? ~v[i-1] : 1'b0;
      half();
    end
    sda_m = mack ? 1'b0 : 1'b1; half(); scl_m = 1'b1;
    if (mack) txr_set++;
    half(); half(); scl_m = 1'b0;
    intent_oe = mack ? ~nxt[7] : 1'b0;
    half(); sda_m = 1'b1;
  endtask

  task automatic partial(input logic [7:0] v, input int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      sda_m = v[i]; half(); scl_m = 1'b1; half(); half(); scl_m = 1'b0; half();
    end
  endtask

  initial begin
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", "sda_oe after reset", sda_oe, 0);
    chk("R11", "rx_valid after reset", rx_valid, 0);
    chk("R11", "tx_req after reset", tx_req, 0);
    running = 1;

    // R1 R4 R5 write to own address
    cur_req = "R5";
    send_start();
    wr_byte({HI, 2'b10, 1'b0}, 1, 0, 0, 0);
    wr_byte(8'hA5, 1, 1, 0, 0);
    wr_byte(8'h3C, 1, 1, 0, 0);
    send_stop();

    // R3 foreign address stays silent
    cur_req = "R3";
    send_start();
    wr_byte({HI, 2'b11, 1'b0}, 0, 0, 0, 0);
    wr_byte(8'h55, 0, 0, 0, 0);
    send_stop();

    // R2 low address bits follow the pins
    cur_req = "R2";
    addr_lo = 2'b01;
    send_start();
    wr_byte({HI, 2'b01, 1'b0}, 1, 0, 0, 0);
    wr_byte(8'h0F, 1, 1, 0, 0);
    send_stop();
    send_start();
    wr_byte({HI, 2'b10, 1'b0}, 0, 0, 0, 0);
    send_stop();

    // R6 STOP mid-byte discards and idles
    cur_req = "R6";
    send_start();
    wr_byte({HI, 2'b01, 1'b0}, 1, 0, 0, 0);
    partial(8'hC3, 4);
    send_stop();
    wr_byte(8'h81, 0, 0, 0, 0);
    send_start();
    wr_byte({HI, 2'b01, 1'b0}, 1, 0, 0, 0);
    wr_byte(8'h7E, 1, 1, 0, 0);
    send_stop();

    // R7 repeated START restarts address reception
    cur_req = "R7";
    send_start();
    wr_byte({HI, 2'b00, 1'b0}, 0, 0, 0, 0);
    send_start();
    wr_byte({HI, 2'b01, 1'b0}, 1, 0, 0, 0);
    wr_byte(8'h24, 1, 1, 0, 0);

    // R8 R9 read after repeated START, master ACK then NACK
    cur_req = "R8";
    tx_q.push_back(8'h96);
    tx_q.push_back(8'h41);
    send_start();
    wr_byte({HI, 2'b01, 1'b1}, 1, 0, 1, 8'h96);
    rd_byte(8'h96, 1, 8'h41);
    cur_req = "R9";
    rd_byte(8'h41, 0, 8'h00);
    wr_byte(8'hFF, 0, 0, 0, 0);
    send_stop();

    // R8 R9 read of all-zero and all-one bytes
    cur_req = "R8";
    tx_q.push_back(8'h00);
    tx_q.push_back(8'hFF);
    send_start();
    wr_byte({HI, 2'b01, 1'b1}, 1, 0, 1, 8'h00);
    rd_byte(8'h00, 1, 8'hFF);
    cur_req = "R9";
    rd_byte(8'hFF, 0, 8'h00);
    send_stop();

    half();
    running = 0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule